// File: doc/BRIEF.md
# Clock Alarm and Interrupt Flag Unit

This block belongs to a real-time clock. At the end of each time update it compares the current seconds, minutes and hours with three alarm bytes. From that comparison it keeps a status byte that holds the update-ended, alarm and periodic event flags, plus a summary interrupt-request bit. The interrupt output follows that summary bit. The time counter and the periodic divider sit outside this block. The counter pulses `upd_done_i` once for each completed update, and the divider pulses `per_flag_i` once for each periodic tick.

Software sets the interrupt enables by writing the control byte. It takes the status back through a read strobe. A read returns the status byte and then clears all of it, including the interrupt line. When a write enables an interrupt whose flag is already waiting, the interrupt is raised immediately. Any other control write drops the interrupt line.

Top module: `rtc_alarm_irq`

## Requirements
- R1: An alarm byte whose bits [7:6] are both 1 (values 0xC0 to 0xFF) matches any current value of its field.
- R2: Each `upd_done_i` pulse sets the update-ended flag, bit 4 of `flags_o`, on the next clock edge.
- R3: The alarm flag, bit 5 of `flags_o`, is set only on an update pulse during which every alarm byte matches its current field, either exactly or as a wildcard.
- R4: Each `per_flag_i` pulse sets the periodic flag, bit 6 of `flags_o`.
- R5: Bit 7 of `flags_o` and `irq_o` are set only by a flag that was clear before the event and whose enable bit in the control byte is 1. The enable bits are bit 6 for periodic, bit 5 for alarm and bit 4 for update-ended. A flag that sets while its enable is 0 leaves `irq_o` low.
- R6: While `flag_rd_i` is high, `flags_o` shows the current status. On the next edge the status byte becomes 0x00 and `irq_o` goes low.
- R7: A control write whose enable bits overlap a pending flag sets bit 7 and raises `irq_o` on the next edge. Any other control write clears bit 7 and lowers `irq_o`, and leaves the other flags unchanged.
- R8: After reset, `flags_o` is 0x00, `irq_o` is low, and `ctl_o` equals CTL_RST (default 0x02) with bits 6, 5 and 3 forced to 0.
- R9: If a status read and a new flag event happen in the same cycle, the new flag is still set after the clear.
- R10: The hour is compared as a raw byte, so the 12-hour PM marker in bit 7 takes part in the match. For example, current hour 0x81 does not match alarm hour 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cur_sec_i | input | 8 | Current seconds byte |
| cur_min_i | input | 8 | Current minutes byte |
| cur_hour_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Alarm seconds byte |
| alm_min_i | input | 8 | Alarm minutes byte |
| alm_hour_i | input | 8 | Alarm hours byte |
| upd_done_i | input | 1 | One-cycle pulse when a time update completes |
| per_flag_i | input | 1 | One-cycle periodic tick |
| ctl_wr_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| flag_rd_i | input | 1 | Status read strobe (clears the status) |
| ctl_o | output | 8 | Control byte |
| flags_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- Update and periodic pulses always leave their flags set.
- A read with no event at the same time always empties the status byte.
- An asserted interrupt always has some event flag behind it.
- An idle cycle changes nothing.
- A fully wildcarded alarm fires on every update.

The directed scenarios are needed to show the rest:
- The exact alarm comparison, partial wildcards, and a PM-marker mismatch.
- Whether an interrupt is raised or held low according to the enables at the time of the event.
- The immediate raise and the clearing effect of control writes.
- The value seen during a read.
- An event that lands in the same cycle as a read.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned BYTE_W = 8;
  // status byte bit positions
  localparam int unsigned ST_IRQ = 7;
  localparam int unsigned ST_PER = 6;
  localparam int unsigned ST_ALM = 5;
  localparam int unsigned ST_UPD = 4;
  // control byte bit positions
  localparam int unsigned CT_PER_EN = 6;
  localparam int unsigned CT_ALM_EN = 5;
  localparam int unsigned CT_UPD_EN = 4;
  localparam int unsigned CT_SQW_EN = 3;
  localparam int unsigned N_EVT = 3;  // per, alm, upd

  localparam logic [BYTE_W-1:0] CT_RST_CLR =
    BYTE_W'((1 << CT_PER_EN) | (1 << CT_ALM_EN) | (1 << CT_SQW_EN));
endpackage

// File: rtl/rtc_field_match.sv
module rtc_field_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] alm_i,
  output logic         hit_o
);
  logic wild;
  assign wild  = &alm_i[W-1 -: 2];
  assign hit_o = wild || (cur_i == alm_i);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned W  = 8,
  parameter int unsigned NF = 3
) (
  input  logic [NF*W-1:0] cur_i,
  input  logic [NF*W-1:0] alm_i,
  output logic            match_o
);
  logic [NF-1:0] hit;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    rtc_field_match #(.W(W)) i_fld (
      .cur_i (cur_i[g*W +: W]),
      .alm_i (alm_i[g*W +: W]),
      .hit_o (hit[g])
    );
  end

  assign match_o = &hit;
endmodule

// File: rtl/rtc_ctl_reg.sv
module rtc_ctl_reg
  import rtc_irq_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CTL_RST = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] ctl_o
);
  localparam logic [BYTE_W-1:0] RST_VAL = CTL_RST & ~CT_RST_CLR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_o <= RST_VAL;
    else if (wr_i) ctl_o <= wdata_i;
  end
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  ev_i,      // {per, alm, upd}
  input  logic [N_EVT-1:0]  en_i,      // current enables
  input  logic              ctl_wr_i,
  input  logic [N_EVT-1:0]  wr_en_i,   // enables being written
  input  logic              rd_i,
  output logic [BYTE_W-1:0] flags_o
);
  logic [BYTE_W-1:0] flags_q, flags_d, base;
  logic [N_EVT-1:0]  pend, fresh, en_eff;
  logic              irq_d;

  // read clear happens before this cycle's events so new flags survive
  assign base   = rd_i ? '0 : flags_q;
  assign pend   = base[ST_PER -: N_EVT];
  assign fresh  = ev_i & ~pend;
  assign en_eff = ctl_wr_i ? wr_en_i : en_i;

  always_comb begin
    irq_d = base[ST_IRQ];
    if (ctl_wr_i) irq_d = |(wr_en_i & pend);
    if (|(fresh & en_eff)) irq_d = 1'b1;
    flags_d = '0;
    flags_d[ST_IRQ] = irq_d;
    flags_d[ST_PER -: N_EVT] = pend | ev_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter logic [7:0] CTL_RST = 8'h02
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] cur_sec_i,
  input  logic [7:0] cur_min_i,
  input  logic [7:0] cur_hour_i,
  input  logic [7:0] alm_sec_i,
  input  logic [7:0] alm_min_i,
  input  logic [7:0] alm_hour_i,
  input  logic       upd_done_i,
  input  logic       per_flag_i,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_wdata_i,
  input  logic       flag_rd_i,
  output logic [7:0] ctl_o,
  output logic [7:0] flags_o,
  output logic       irq_o
);
  localparam int unsigned NF = 3;

  logic             match;
  logic [N_EVT-1:0] ev;

  rtc_alarm_match #(.W(BYTE_W), .NF(NF)) i_match (
    .cur_i   ({cur_hour_i, cur_min_i, cur_sec_i}),
    .alm_i   ({alm_hour_i, alm_min_i, alm_sec_i}),
    .match_o (match)
  );

  rtc_ctl_reg #(.CTL_RST(CTL_RST)) i_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl_o)
  );

  assign ev = {per_flag_i, upd_done_i & match, upd_done_i};

  rtc_flag_reg i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .en_i     (ctl_o[CT_PER_EN -: N_EVT]),
    .ctl_wr_i (ctl_wr_i),
    .wr_en_i  (ctl_wdata_i[CT_PER_EN -: N_EVT]),
    .rd_i     (flag_rd_i),
    .flags_o  (flags_o)
  );

  assign irq_o = flags_o[ST_IRQ];
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] alm_sec_i,
  input logic [7:0] alm_min_i,
  input logic [7:0] alm_hour_i,
  input logic       upd_done_i,
  input logic       per_flag_i,
  input logic       ctl_wr_i,
  input logic       flag_rd_i,
  input logic [7:0] flags_o,
  input logic       irq_o
);
  AST_WILD_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_done_i && (&alm_sec_i[7:6]) && (&alm_min_i[7:6]) && (&alm_hour_i[7:6]))
    |=> flags_o[5]); // R1

  AST_UPD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i |=> flags_o[4]); // R2

  AST_PER_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_flag_i |=> flags_o[6]); // R4

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_o[6:4] != 3'b000)); // R5

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !upd_done_i && !per_flag_i) |=> (flags_o == 8'h00 && !irq_o)); // R6

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_done_i && !per_flag_i && !ctl_wr_i && !flag_rd_i)
    |=> ($stable(flags_o) && $stable(irq_o))); // R5
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alm_sec_i  (alm_sec_i),
  .alm_min_i  (alm_min_i),
  .alm_hour_i (alm_hour_i),
  .upd_done_i (upd_done_i),
  .per_flag_i (per_flag_i),
  .ctl_wr_i   (ctl_wr_i),
  .flag_rd_i  (flag_rd_i),
  .flags_o    (flags_o),
  .irq_o      (irq_o)
);

// File: tb/test_rtc_alarm_irq.sv
module test_rtc_alarm_irq;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
  logic [7:0] alm_sec = '0, alm_min = '0, alm_hour = '0;
  logic       upd = 1'b0, per = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctl, flags;
  logic       irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_irq i_rtc_alarm_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .cur_sec_i(cur_sec), .cur_min_i(cur_min), .cur_hour_i(cur_hour),
    .alm_sec_i(alm_sec), .alm_min_i(alm_min), .alm_hour_i(alm_hour),
    .upd_done_i(upd), .per_flag_i(per), .ctl_wr_i(wr), .ctl_wdata_i(wdata),
    .flag_rd_i(rd), .ctl_o(ctl), .flags_o(flags), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                          logic [7:0] as, logic [7:0] am, logic [7:0] ah);
    cur_sec = s; cur_min = m; cur_hour = h;
    alm_sec = as; alm_min = am; alm_hour = ah;
  endtask

  task automatic pulse_upd();
    @(negedge clk) upd = 1'b1;
    @(negedge clk) upd = 1'b0;
  endtask

  task automatic pulse_per();
    @(negedge clk) per = 1'b1;
    @(negedge clk) per = 1'b0;
  endtask

  task automatic write_ctl(logic [7:0] d);
    @(negedge clk) begin wr = 1'b1; wdata = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  task automatic read_flags(string req, logic [7:0] exp);
    @(negedge clk) rd = 1'b1;
    #1 chk(req, flags, exp);
    @(negedge clk) rd = 1'b0;
    chk({req, " R6 clear"}, flags, 8'h00);
    chk({req, " R6 irq"}, {7'b0, irq}, 8'h00);
  endtask

  task automatic t_reset();
    chk("R8 flags", flags, 8'h00);
    chk("R8 irq", {7'b0, irq}, 8'h00);
    chk("R8 ctl", ctl, 8'h02);
  endtask

  task automatic t_update_nomatch();
    set_time(8'h10, 8'h20, 8'h03, 8'h11, 8'h20, 8'h03);
    pulse_upd();
    chk("R2 R3 no alarm", flags, 8'h10);
    chk("R5 irq off", {7'b0, irq}, 8'h00);
    read_flags("R6 read", 8'h10);
  endtask

  task automatic t_exact_match();
    set_time(8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12);
    pulse_upd();
    chk("R3 exact", flags, 8'h30);
    read_flags("R3 read", 8'h30);
    pulse_per();
    chk("R3 no update no alarm", flags, 8'h40);
    read_flags("R4 read", 8'h40);
  endtask

  task automatic t_wildcard();
    set_time(8'h07, 8'h41, 8'h22, 8'hC0, 8'hFF, 8'hC5);
    pulse_upd();
    chk("R1 all wild", flags, 8'h30);
    read_flags("R1 read", 8'h30);
    set_time(8'h07, 8'h41, 8'h22, 8'hC3, 8'h40, 8'h22);
    pulse_upd();
    chk("R1 partial wild miss", flags, 8'h10);
    read_flags("R1 read2", 8'h10);
  endtask

  task automatic t_pm_hour();
    set_time(8'h00, 8'h15, 8'h81, 8'h00, 8'h15, 8'h01);
    pulse_upd();
    chk("R10 pm mismatch", flags, 8'h10);
    read_flags("R10 read", 8'h10);
    set_time(8'h00, 8'h15, 8'h81, 8'h00, 8'h15, 8'h81);
    pulse_upd();
    chk("R10 pm match", flags, 8'h30);
    read_flags("R10 read2", 8'h30);
  endtask

  task automatic t_enable_irq();
    write_ctl(8'h12);
    chk("R7 ctl written", ctl, 8'h12);
    chk("R7 no pending", {7'b0, irq}, 8'h00);
    set_time(8'h01, 8'h02, 8'h03, 8'h09, 8'h02, 8'h03);
    pulse_upd();
    chk("R5 upd irq", flags, 8'h90);
    chk("R5 irq line", {7'b0, irq}, 8'h01);
    read_flags("R5 read", 8'h90);
    pulse_per();
    chk("R5 per disabled", flags, 8'h40);
    chk("R5 per no irq", {7'b0, irq}, 8'h00);
    write_ctl(8'h52);
    chk("R7 immediate", flags, 8'hC0);
    chk("R7 immediate irq", {7'b0, irq}, 8'h01);
    write_ctl(8'h02);
    chk("R7 lower", flags, 8'h40);
    chk("R7 lower irq", {7'b0, irq}, 8'h00);
    write_ctl(8'h12);
    pulse_upd();
    chk("R5 new upd with pending per", flags, 8'hD0);
    write_ctl(8'h02);
    read_flags("R5 read2", 8'h50);
  endtask

  task automatic t_read_collide();
    pulse_upd();
    chk("R9 setup", flags, 8'h10);
    @(negedge clk) begin rd = 1'b1; per = 1'b1; end
    @(negedge clk) begin rd = 1'b0; per = 1'b0; end
    chk("R9 survives", flags, 8'h40);
    read_flags("R9 read", 8'h40);
  endtask

  task automatic t_reset_again();
    write_ctl(8'h7A);
    pulse_upd();
    @(negedge clk) rst_n = 1'b0;
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_update_nomatch();
    t_exact_match();
    t_wildcard();
    t_pm_hour();
    t_enable_irq();
    t_read_collide();
    t_reset_again();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule